// File: doc/BRIEF.md
# DMA request router

This block sits between four asynchronous external DMA request pins and a bank of DMA channels. Each channel holds a routing entry that claims one of the four request/acknowledge pin pairs, or none. The block brings each pin into the clock domain, conditions it according to a per-pin mode, and raises one request per channel. When a channel reports that it performs a transfer, the block pulses the acknowledge pin paired with the claimed request line.

Each pin has its own mode: level or edge sensitivity, with a polarity bit that means active-high or active-low in level mode and rising or falling in edge mode. In edge mode a detected edge is held as a pending request until the owning channel is acknowledged. Software configures the block through two write strobes, one for routing entries and one for pin modes. A routing write that would give a line to a second channel is refused and flagged.

Top module: `dma_req_router`

## Requirements
- R1: After reset, channel 0 owns line A (index 0), channel 1 owns line B (index 1), lines C and D are unowned, every line is in level mode active-low, all `ch_req` bits are 0, all `ack_pin_n` bits are 1 and `cfg_err` is 0.
- R2: A routing value of 0 selects no line, values 1, 2, 3, 4 select lines A, B, C, D (pin index value-1), and values 5 to 7 select no line.
- R3: A routing write that names a line owned by a different channel leaves every routing entry unchanged and sets `cfg_err`; an accepted routing write clears `cfg_err`. A channel may rewrite the line it already owns.
- R4: In level mode the owning channel's `ch_req` follows the active level of its pin, with the change visible after the second rising clock edge following the pin change.
- R5: In edge mode a selected edge on the pin makes the owning channel's `ch_req` go high after the third rising clock edge following the edge, and it stays high without further pin activity until acknowledged.
- R6: When `ch_xfer[c]` is high at a rising edge and channel c owns line L, `ack_pin_n[L]` is low for exactly the following cycle, and the pending edge request of line L is cleared.
- R7: If a new selected edge is detected in the same cycle as an acknowledge of that line, the pending request stays set.
- R8: A channel that owns no line keeps its `ch_req` at 0, and its `ch_xfer` drives no acknowledge pin.
- R9: A mode write to a line clears that line's pending edge request.
- R10: Mode write fields: `cfg_mode_edge` 1 means edge mode and 0 level mode; `cfg_mode_pol` 1 means active-high or rising, 0 means active-low or falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pin | input | 4 | Asynchronous external request pins, index 0..3 = A..D |
| ack_pin_n | output | 4 | Active-low acknowledge pins, index 0..3 = A..D |
| ch_req | output | NUM_CH | Request to each DMA channel |
| ch_xfer | input | NUM_CH | Per-channel transfer strobe from the DMA engine |
| cfg_route_we | input | 1 | Routing entry write strobe |
| cfg_route_ch | input | CHW | Channel whose routing entry is written |
| cfg_route_val | input | 3 | Routing value (0 none, 1..4 lines A..D) |
| cfg_mode_we | input | 1 | Pin mode write strobe |
| cfg_mode_line | input | 2 | Line whose mode is written |
| cfg_mode_edge | input | 1 | 1 edge mode, 0 level mode |
| cfg_mode_pol | input | 1 | 1 high/rising, 0 low/falling |
| cfg_err | output | 1 | Set by a refused routing write |

## Verification
The two functions that can collide are edge capture and acknowledge on the same line: a second falling edge is timed so that its synchronised detection lands on the very clock edge at which the owning channel's transfer strobe is sampled. The bench first lets the earlier edge become pending, returns the pin high, then drops it again and raises the strobe exactly two cycles later. It judges the outcome by seeing the acknowledge pulse on the pin while the channel request remains high afterwards, and then shows that a plain acknowledge without a new edge does clear it.

// File: rtl/dma_router_pkg.sv
package dma_router_pkg;
  localparam int LINE_IDX_W = 2;
  localparam int LINES      = 1 << LINE_IDX_W;

  typedef struct packed {
    logic                  en;
    logic [LINE_IDX_W-1:0] idx;
  } route_t;

  // Routing value: 0 = none, k+1 = line k, beyond the line count = none.
  function automatic route_t decode_route(input logic [LINE_IDX_W:0] v);
    route_t r;
    r.en  = (v != '0) && (v <= (LINE_IDX_W+1)'(LINES));
    r.idx = LINE_IDX_W'(v - 1'b1);
    return r;
  endfunction

  function automatic logic level_hit(input logic cur, input logic pol);
    return pol ? cur : ~cur;
  endfunction

  function automatic logic edge_hit(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction
endpackage

// File: rtl/dma_line_cond.sv
module dma_line_cond
  import dma_router_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic mode_we,
  input  logic mode_edge,
  input  logic mode_pol,
  input  logic ack_fire,
  output logic line_req,
  output logic edge_seen,
  output logic pend
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   edge_mode_q;
  logic                   pol_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  // Pins idle high through pull-ups, so the chain resets to 1.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_mode_q <= 1'b0;
      pol_q       <= 1'b0;
    end else if (mode_we) begin
      edge_mode_q <= mode_edge;
      pol_q       <= mode_pol;
    end
  end

  assign edge_seen = edge_mode_q & edge_hit(cur, prev_q, pol_q);

  // A fresh edge outranks an acknowledge; a mode write outranks both.
  always_ff @(posedge clk) begin
    if (!rst_n)         pend <= 1'b0;
    else if (mode_we)   pend <= 1'b0;
    else if (edge_seen) pend <= 1'b1;
    else if (ack_fire)  pend <= 1'b0;
  end

  assign line_req = edge_mode_q ? pend : level_hit(cur, pol_q);
endmodule

// File: rtl/dma_route_table.sv
module dma_route_table
  import dma_router_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CHW-1:0]          wr_ch,
  input  logic [LINE_IDX_W:0]     wr_val,
  output route_t [NUM_CH-1:0]     routes,
  output logic                    wr_reject,
  output logic                    cfg_err
);
  route_t claim;
  logic   conflict;
  logic   ch_ok;

  assign claim = decode_route(wr_val);
  assign ch_ok = (int'(wr_ch) < NUM_CH);

  always_comb begin
    conflict = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if ((c != int'(wr_ch)) && routes[c].en && claim.en && (routes[c].idx == claim.idx))
        conflict = 1'b1;
    end
  end

  assign wr_reject = wr_en & ch_ok & conflict;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        routes[c].en  <= (c < 2);
        routes[c].idx <= (c < 2) ? LINE_IDX_W'(c) : '0;
      end
      cfg_err <= 1'b0;
    end else if (wr_en && ch_ok) begin
      if (conflict) begin
        cfg_err <= 1'b1;
      end else begin
        routes[wr_ch] <= claim;
        cfg_err       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_ack_map.sv
module dma_ack_map
  import dma_router_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  route_t [NUM_CH-1:0] routes,
  input  logic [NUM_CH-1:0]   ch_xfer,
  input  logic [LINES-1:0]    line_req,
  output logic [NUM_CH-1:0]   ch_req,
  output logic [LINES-1:0]    ack_fire,
  output logic [LINES-1:0]    ack_pin_n
);
  logic [LINES-1:0] ack_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chreq
    assign ch_req[c] = routes[c].en & line_req[routes[c].idx];
  end

  always_comb begin
    ack_fire = '0;
    for (int l = 0; l < LINES; l++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (routes[c].en && (routes[c].idx == LINE_IDX_W'(l)) && ch_xfer[c])
          ack_fire[l] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= '0;
    else        ack_q <= ack_fire;
  end

  assign ack_pin_n = ~ack_q;
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_router_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CHW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINES-1:0]      req_pin,
  output logic [LINES-1:0]      ack_pin_n,
  output logic [NUM_CH-1:0]     ch_req,
  input  logic [NUM_CH-1:0]     ch_xfer,
  input  logic                  cfg_route_we,
  input  logic [CHW-1:0]        cfg_route_ch,
  input  logic [LINE_IDX_W:0]   cfg_route_val,
  input  logic                  cfg_mode_we,
  input  logic [LINE_IDX_W-1:0] cfg_mode_line,
  input  logic                  cfg_mode_edge,
  input  logic                  cfg_mode_pol,
  output logic                  cfg_err
);
  route_t [NUM_CH-1:0] routes;
  logic                wr_reject;
  logic [LINES-1:0]    mode_we;
  logic [LINES-1:0]    line_req;
  logic [LINES-1:0]    edge_seen;
  logic [LINES-1:0]    pend;
  logic [LINES-1:0]    ack_fire;

  dma_route_table #(.NUM_CH(NUM_CH)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_route_we),
    .wr_ch     (cfg_route_ch),
    .wr_val    (cfg_route_val),
    .routes    (routes),
    .wr_reject (wr_reject),
    .cfg_err   (cfg_err)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_line
    assign mode_we[l] = cfg_mode_we & (cfg_mode_line == LINE_IDX_W'(l));

    dma_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (req_pin[l]),
      .mode_we   (mode_we[l]),
      .mode_edge (cfg_mode_edge),
      .mode_pol  (cfg_mode_pol),
      .ack_fire  (ack_fire[l]),
      .line_req  (line_req[l]),
      .edge_seen (edge_seen[l]),
      .pend      (pend[l])
    );
  end

  dma_ack_map #(.NUM_CH(NUM_CH)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .routes    (routes),
    .ch_xfer   (ch_xfer),
    .line_req  (line_req),
    .ch_req    (ch_req),
    .ack_fire  (ack_fire),
    .ack_pin_n (ack_pin_n)
  );
endmodule

// File: rtl/dma_router_checker.sv
module dma_router_checker
  import dma_router_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input route_t [NUM_CH-1:0] routes,
  input logic [NUM_CH-1:0]   ch_req,
  input logic [LINES-1:0]    ack_pin_n,
  input logic                cfg_err,
  input logic                wr_reject,
  input logic [LINES-1:0]    mode_we,
  input logic [LINES-1:0]    edge_seen,
  input logic [LINES-1:0]    pend,
  input logic [LINES-1:0]    ack_fire
);
  for (genvar l = 0; l < LINES; l++) begin : g_l
    logic [NUM_CH-1:0] claim;
    always_comb begin
      for (int c = 0; c < NUM_CH; c++)
        claim[c] = routes[c].en && (routes[c].idx == LINE_IDX_W'(l));
    end

    assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(claim));

    assert_ack_from_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_pin_n[l] |-> $past(ack_fire[l]));

    assert_ack_clears_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire[l] && !edge_seen[l] && !mode_we[l] |=> !pend[l]);

    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen[l] && ack_fire[l] && !mode_we[l] |=> pend[l]);

    assert_mode_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we[l] |=> !pend[l]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_unrouted_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !routes[c].en |-> !ch_req[c]);
  end

  assert_err_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(wr_reject));
endmodule

bind dma_req_router dma_router_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .routes    (routes),
  .ch_req    (ch_req),
  .ack_pin_n (ack_pin_n),
  .cfg_err   (cfg_err),
  .wr_reject (wr_reject),
  .mode_we   (mode_we),
  .edge_seen (edge_seen),
  .pend      (pend),
  .ack_fire  (ack_fire)
);

// File: tb/dma_req_router_test.sv
module dma_req_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_pin = 4'hF;
  logic [3:0] ack_pin_n;
  logic [3:0] ch_req;
  logic [3:0] ch_xfer = '0;
  logic       cfg_route_we = 1'b0;
  logic [1:0] cfg_route_ch = '0;
  logic [2:0] cfg_route_val = '0;
  logic       cfg_mode_we = 1'b0;
  logic [1:0] cfg_mode_line = '0;
  logic       cfg_mode_edge = 1'b0;
  logic       cfg_mode_pol = 1'b0;
  logic       cfg_err;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dma_req_router uut (
    .clk(clk), .rst_n(rst_n), .req_pin(req_pin), .ack_pin_n(ack_pin_n),
    .ch_req(ch_req), .ch_xfer(ch_xfer),
    .cfg_route_we(cfg_route_we), .cfg_route_ch(cfg_route_ch), .cfg_route_val(cfg_route_val),
    .cfg_mode_we(cfg_mode_we), .cfg_mode_line(cfg_mode_line),
    .cfg_mode_edge(cfg_mode_edge), .cfg_mode_pol(cfg_mode_pol), .cfg_err(cfg_err)
  );

  // Level-mode vectors for line A: {pol, pin, expected ch_req[0]}
  localparam logic [2:0] LVL_VEC [4] = '{3'b111, 3'b100, 3'b001, 3'b010};

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_route(input logic [1:0] ch, input logic [2:0] val);
    cfg_route_we = 1'b1; cfg_route_ch = ch; cfg_route_val = val;
    cyc(1);
    cfg_route_we = 1'b0;
  endtask

  task automatic write_mode(input logic [1:0] line, input logic edge_m, input logic pol);
    cfg_mode_we = 1'b1; cfg_mode_line = line; cfg_mode_edge = edge_m; cfg_mode_pol = pol;
    cyc(1);
    cfg_mode_we = 1'b0;
  endtask

  task automatic pulse_xfer(input int ch);
    ch_xfer[ch] = 1'b1;
    cyc(1);
    ch_xfer = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 ch_req", ch_req, 4'b0000);
    check("R1 ack", ack_pin_n, 4'hF);
    check("R1 err", {3'b0, cfg_err}, 4'b0000);

    // R1/R4: line A owned by ch0, active-low, two-edge sync delay
    req_pin[0] = 1'b0;
    cyc(1);
    check("R4 not yet", ch_req, 4'b0000);
    cyc(1);
    check("R4 level after sync", ch_req, 4'b0001);
    req_pin[2] = 1'b0;
    cyc(2);
    check("R1 line C unowned", ch_req, 4'b0001);
    req_pin = 4'hF;
    cyc(3);

    // R4/R10 vector table on line A
    for (int i = 0; i < 4; i++) begin
      write_mode(2'd0, 1'b0, LVL_VEC[i][2]);
      req_pin[0] = LVL_VEC[i][1];
      cyc(3);
      check("R4 R10 level vector", {3'b0, ch_req[0]}, {3'b0, LVL_VEC[i][0]});
    end

    // R6 acknowledge on A
    pulse_xfer(0);
    check("R6 ack A low", ack_pin_n, 4'b1110);
    cyc(1);
    check("R6 ack one cycle", ack_pin_n, 4'hF);

    // R5 edge mode, falling, line B / ch1
    write_mode(2'd1, 1'b1, 1'b0);
    req_pin[1] = 1'b0;
    cyc(2);
    check("R5 not yet", {3'b0, ch_req[1]}, 4'b0000);
    cyc(1);
    check("R5 pending", {3'b0, ch_req[1]}, 4'b0001);
    cyc(4);
    check("R5 held", {3'b0, ch_req[1]}, 4'b0001);
    pulse_xfer(1);
    check("R6 ack B low", ack_pin_n, 4'b1101);
    cyc(1);
    check("R6 ack B released", ack_pin_n, 4'hF);
    check("R6 pending cleared", {3'b0, ch_req[1]}, 4'b0000);

    // R7 edge and acknowledge in the same cycle
    req_pin[1] = 1'b1;
    cyc(3);
    req_pin[1] = 1'b0;
    cyc(3);
    check("R7 setup pending", {3'b0, ch_req[1]}, 4'b0001);
    req_pin[1] = 1'b1;
    cyc(3);
    req_pin[1] = 1'b0;
    cyc(2);
    pulse_xfer(1);
    check("R7 ack issued", ack_pin_n, 4'b1101);
    cyc(1);
    check("R7 pending kept", {3'b0, ch_req[1]}, 4'b0001);
    pulse_xfer(1);
    cyc(1);
    check("R7 later ack clears", {3'b0, ch_req[1]}, 4'b0000);

    // R9 mode write clears pending
    req_pin[1] = 1'b1;
    cyc(3);
    req_pin[1] = 1'b0;
    cyc(3);
    check("R9 setup pending", {3'b0, ch_req[1]}, 4'b0001);
    write_mode(2'd1, 1'b1, 1'b0);
    check("R9 cleared by mode write", {3'b0, ch_req[1]}, 4'b0000);

    // R3 conflicting claim of line A by ch2
    write_route(2'd2, 3'd1);
    check("R3 err set", {3'b0, cfg_err}, 4'b0001);
    req_pin[0] = 1'b0;
    cyc(2);
    check("R3 routes unchanged", {ch_req[2], ch_req[0]}, 4'b0001);
    write_route(2'd2, 3'd3);
    check("R3 err cleared", {3'b0, cfg_err}, 4'b0000);
    req_pin[2] = 1'b0;
    cyc(2);
    check("R2 value 3 is line C", {3'b0, ch_req[2]}, 4'b0001);
    write_route(2'd2, 3'd3);
    check("R3 owner rewrite accepted", {3'b0, cfg_err}, 4'b0000);

    // R2/R8 out-of-range value is no line
    write_route(2'd3, 3'd6);
    req_pin[3] = 1'b0;
    cyc(2);
    check("R2 value 6 none", {3'b0, ch_req[3]}, 4'b0000);
    pulse_xfer(3);
    check("R8 no ack from unrouted", ack_pin_n, 4'hF);
    write_route(2'd3, 3'd4);
    check("R2 value 4 is line D", {3'b0, ch_req[3]}, 4'b0001);

    // R8 channel 0 released
    write_route(2'd0, 3'd0);
    check("R8 released channel quiet", {3'b0, ch_req[0]}, 4'b0000);
    pulse_xfer(0);
    check("R8 released channel no ack", ack_pin_n, 4'hF);
    write_route(2'd3, 3'd1);
    check("R3 freed line accepted", {3'b0, cfg_err}, 4'b0000);
    check("R2 value 1 is line A", {3'b0, ch_req[3]}, 4'b0001);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule